// File: doc/BRIEF.md
# Serial Flash Chip-Erase Command Controller

This block is the command side of a serial NOR flash device, limited to the erase of the whole array. A host frames each instruction by pulling chip select low and clocking opcode bits in on the serial data line. The block shifts those bits in, counts them, and acts only when chip select returns high directly after the eighth bit. Three opcodes are decoded: one sets the write-enable latch, one streams the status byte back, and one starts an erase of the whole array. An erase starts only if the latch is set and all four protection inputs are zero.

An accepted erase runs as a self-timed countdown measured in system clocks. While it runs, the busy flag in the status byte reads 1, and only status reads are honoured. At the end of the countdown every word of the small internal array becomes all ones. Chip select, serial clock and data are sampled by the system clock through two-stage synchronisers, so the serial clock must be several times slower than the system clock.

The serial interface has no back-pressure. The host alone paces the transfer with the serial clock. The array readback port is a plain combinational lookup with no handshake.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, sdo is 0, and array word i holds (37*i+5) mod 256.
- R2: Opcode 0x06 (write-enable), sent MSB first and closed by chip select rising after exactly 8 bits, sets the latch while no erase runs. The latch is status bit 1.
- R3: Opcode 0x05 (read-status) makes sdo present the status byte MSB first, changing on each falling serial clock edge after the opcode. Bit 0 is busy, bit 1 is the latch, and bits 7..2 are 0. The byte repeats for as long as chip select stays low.
- R4: A transfer whose chip select rises after 7 or 9 bits changes neither the latch, the busy flag nor the array.
- R5: Opcode 0xC7 (chip-erase) with the latch clear is ignored: busy stays 0 and the array is unchanged.
- R6: Chip-erase while any bit of protect_bits is 1 is ignored: busy stays 0, the array is unchanged, and the latch keeps its value.
- R7: An accepted chip-erase holds busy at 1 for ERASE_CYCLES system clocks, after which busy returns to 0.
- R8: After an accepted erase completes, every array word reads all ones.
- R9: The latch is cleared when an accepted erase starts, so it reads 0 while busy is 1 and after the erase.
- R10: While busy is 1, write-enable and chip-erase opcodes have no effect, and read-status still works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data input, sampled on rising sck |
| sdo | output | 1 | Serial status output, changes on falling sck |
| protect_bits | input | 4 | Protection bits, where any 1 blocks the erase |
| rd_addr | input | ADDR_W | Array readback address |
| rd_data | output | WORD_W | Array word at rd_addr |

## Verification
On every cycle, the assertions check that busy only rises with the latch set and the protection bits clear, and that the latch is cleared as busy rises and cannot return during the erase. They also check that the array holds still unless an erase finishes, that a finished erase leaves all ones, that the timer count stays in range, and that the bit count restarts on each chip-select fall. Only the bench's serial scenarios can show the rest. These cover rejection at 7 and 9 bits, the bit order of the status stream, and busy being seen by polling until it clears. They also show the array content before and after each kind of attempt.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_CE   = 8'hC7;

  function automatic logic [7:0] seed_byte(input int idx);
    return 8'((idx * 37 + 5) % 256);
  endfunction
endpackage

// File: rtl/fec_serial.sv
module fec_serial
  import fec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic [7:0] status,
  output logic       cmd_valid,
  output logic [7:0] cmd_op,
  output logic       sdo
);
  logic [2:0] cs_q, sck_q;
  logic [1:0] sdi_q;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic       rd_act, show;
  logic [2:0] ptr, cur;

  logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall;
  logic [7:0] next_sh;

  assign cs_low   = !cs_q[1];
  assign cs_fall  = !cs_q[1] && cs_q[2];
  assign cs_rise  = cs_q[1] && !cs_q[2];
  assign sck_rise = cs_low && sck_q[1] && !sck_q[2];
  assign sck_fall = cs_low && !sck_q[1] && sck_q[2];
  assign next_sh  = {shreg[6:0], sdi_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= 3'b000;
      sdi_q <= 2'b00;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      rd_act  <= 1'b0;
      show    <= 1'b0;
      ptr     <= '0;
      cur     <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      rd_act  <= 1'b0;
      show    <= 1'b0;
    end else if (cs_rise) begin
      rd_act  <= 1'b0;
      show    <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg <= next_sh;
        if (bit_cnt != 4'hF) bit_cnt <= bit_cnt + 4'd1;
        if (bit_cnt == 4'd7 && next_sh == OP_RDSR) begin
          rd_act <= 1'b1;
          ptr    <= 3'd7;
        end
      end
      if (sck_fall && rd_act) begin
        cur  <= ptr;
        ptr  <= ptr - 3'd1;
        show <= 1'b1;
      end
    end
  end

  assign cmd_valid = cs_rise && (bit_cnt == 4'd8);
  assign cmd_op    = shreg;
  assign sdo       = show && status[cur];

  // R4: every frame starts counting from zero
  p_cnt_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bit_cnt == 4'd0));
  // R3: output quiet once chip select has been high for two samples
  p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q[1] && cs_q[2]) |-> !sdo);
endmodule

// File: rtl/fec_erase_timer.sv
module fec_erase_timer #(
  parameter int ERASE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(ERASE_CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R7: count stays inside the programmed window
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CNT_W'(ERASE_CYCLES)));
  // R10: no restart while an erase runs
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/fec_array.sv
module fec_array
  import fec_pkg::*;
#(
  parameter int MEM_WORDS = 16,
  parameter int WORD_W    = 8,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [MEM_WORDS-1:0][WORD_W-1:0] mem;

  for (genvar i = 0; i < MEM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem[i] <= WORD_W'(seed_byte(i));
      else if (clear) mem[i] <= '1;
    end
  end

  assign rd_data = mem[rd_addr];

  // R5 R6: contents hold unless an erase completes
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> $stable(mem));
  // R8: a completed erase leaves all ones
  p_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mem == '1));
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int MEM_WORDS    = 16,
  parameter int WORD_W       = 8,
  parameter int ERASE_CYCLES = 1000,
  localparam int ADDR_W      = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  input  logic [3:0]        protect_bits,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic       cmd_valid, start, wip, done, wel;
  logic [7:0] cmd_op, status;

  assign status = {6'b0, wel, wip};

  fec_serial u_serial (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .status(status), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .sdo(sdo)
  );

  assign start = cmd_valid && !wip && (cmd_op == OP_CE) && wel
                 && (protect_bits == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         wel <= 1'b0;
    else if (start)                                     wel <= 1'b0;
    else if (cmd_valid && !wip && cmd_op == OP_WREN)    wel <= 1'b1;
  end

  fec_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(done)
  );

  fec_array #(.MEM_WORDS(MEM_WORDS), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .clear(done), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // R5: erase only starts from a set latch
  p_wip_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));
  // R6: erase only starts with protection clear
  p_wip_unprot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(protect_bits) == 4'b0000));
  // R9: latch drops as the erase begins
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);
  // R10: latch cannot be set during the erase
  p_wel_low_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !wel) |=> !wel);
endmodule

// File: tb/sim_flash_erase_ctrl.sv
module sim_flash_erase_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 8;
  localparam int WORDS = 16;
  localparam int ECYC  = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [3:0] prot = 4'b0;
  logic [3:0] rd_addr = '0;
  logic sdo;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit m_wel, m_erased;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_ctrl #(.MEM_WORDS(WORDS), .WORD_W(8), .ERASE_CYCLES(ECYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
    .protect_bits(prot), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_word(int i, bit erased);
    return erased ? 8'hFF : 8'((i * 37 + 5) % 256);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [15:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      waitc(HALF); sck = 1'b1;
      waitc(HALF); sck = 1'b0;
    end
  endtask

  task automatic send(logic [7:0] op, int n);
    logic [15:0] v;
    v = {op, 8'h00} >> (16 - n);
    if (n > 8) v = {op, 8'h00} >> (16 - n);
    cs_n = 1'b0; waitc(4);
    shift_bits(v, n);
    waitc(2); cs_n = 1'b1; waitc(12);
  endtask

  task automatic read_status(output logic [7:0] s);
    cs_n = 1'b0; waitc(4);
    shift_bits(16'h0005, 8);
    for (int i = 7; i >= 0; i--) begin
      waitc(HALF); s[i] = sdo;
      sck = 1'b1; waitc(HALF); sck = 1'b0;
    end
    waitc(2); cs_n = 1'b1; waitc(12);
  endtask

  task automatic check_status(string req, bit wip);
    logic [7:0] s;
    read_status(s);
    check(req, s, {6'b0, m_wel, wip});
  endtask

  task automatic check_array(string req);
    for (int i = 0; i < WORDS; i++) begin
      rd_addr = 4'(i); waitc(1);
      check(req, rd_data, exp_word(i, m_erased));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; waitc(3);
    rst_n = 1'b1; waitc(3);
    m_wel = 0; m_erased = 0;
  endtask

  task automatic full_erase();
    logic [7:0] s;
    int polls;
    send(8'h06, 8); m_wel = 1;
    prot = 4'b0;
    send(8'hC7, 8); m_wel = 0;
    check_status("R7 busy after start R9", 1'b1);
    send(8'h06, 8);                       // R10: ignored while busy
    send(8'hC7, 8);
    check_status("R10 wren ignored busy", 1'b1);
    polls = 0;
    do begin read_status(s); polls++; end while (s[0] && polls < 40);
    check("R7 busy clears", s, 8'h00);
    m_erased = 1;
    check_array("R8 all ones");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    do_reset();
    check("R1 sdo reset", sdo, 1'b0);
    check_status("R1 status reset", 1'b0);
    check_array("R1 seed");

    send(8'hC7, 8);                       // R5 no latch
    check_status("R5 no wel", 1'b0);
    check_array("R5 array");

    send(8'h06, 7);                       // R4 short
    check_status("R4 7 bits", 1'b0);
    send(8'h06, 9);                       // R4 long
    check_status("R4 9 bits", 1'b0);

    send(8'h06, 8); m_wel = 1;
    check_status("R2 wel set R3", 1'b0);

    send(8'hC7, 7);
    check_status("R4 ce 7 bits", 1'b0);
    send(8'hC7, 9);
    check_status("R4 ce 9 bits", 1'b0);
    check_array("R4 array");

    prot = 4'b1000; send(8'hC7, 8);
    check_status("R6 tb bit", 1'b0);
    prot = 4'b0001; send(8'hC7, 8);
    check_status("R6 bp0", 1'b0);
    check_array("R6 array");
    prot = 4'b0;

    full_erase();
    do_reset();

    for (int it = 0; it < 50; it++) begin
      int op, len;
      op  = int'($urandom % 4);
      len = ($urandom % 2) ? 8 : (($urandom % 2) ? 7 : 9);
      case (op)
        0: begin
          send(8'h06, len);
          if (len == 8) m_wel = 1;
          check_status("R2 R4 rand wren", 1'b0);
        end
        1: begin
          prot = ($urandom % 2) ? 4'b0 : 4'($urandom % 15 + 1);
          if (len == 8 && m_wel && prot == 4'b0) begin
            prot = 4'b0;
            full_erase();
            if ($urandom % 2) do_reset();
          end else begin
            send(8'hC7, len);
            check_status("R5 R6 rand ce", 1'b0);
          end
          prot = 4'b0;
        end
        2: check_status("R3 rand rdsr", 1'b0);
        default: check_array("R8 rand array");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule